// File: doc/BRIEF.md
# Buffered Serial Frame Receiver

This block receives framed synchronous serial words and delivers them to a host one at a time. A frame-sync pulse marks the first bit of a word. Bits enter a shift register most significant bit first, one bit for each sample-enable strobe. The strobe marks a rising edge of the serial clock, already brought into the system clock domain. A finished word passes through a holding buffer into a data register that the host can read. A host or DMA read strobe empties the data register, and any words still waiting then move forward one stage per cycle.

The receive path has three stages, so its overrun behaviour is defined. A word finishes in the shift register and stays there while both later stages are occupied. The next incoming frame overwrites it, and a sticky overrun flag records the loss. A frame-sync pulse that arrives in the middle of a frame is either ignored or made to restart reception, depending on a control input. A restart also discards any word waiting in the holding buffer and raises a sticky frame-sync error flag. Each flag clears with its own write-one-to-clear pulse.

Top module: `serial_frame_rx`

## Requirements
- R1: When `fsync` is high on a cycle with `bit_en` high and no frame is active, a new frame starts, and that cycle's `sdata` bit is the most significant bit. Each later `bit_en` cycle shifts in the next bit. After WIDTH bits the word is complete. Cycles with `bit_en` low shift nothing. A complete word reaches `rd_data` with `rd_rdy` high.
- R2: `rd_stb` on a cycle with `rd_rdy` high drops `rd_rdy` on the next cycle. `rd_stb` while `rd_rdy` is low has no effect.
- R3: While `rd_rdy` is high and no read occurs, `rd_data` holds its value. A word in the holding buffer is copied into the data register only when the data register is empty.
- R4: After a read, a word waiting in the holding buffer appears on `rd_data` with `rd_rdy` high two cycles after the read cycle. A word held complete in the shift register moves into the holding buffer in the same cycle.
- R5: A word completes in the shift register while the holding buffer and the data register are both full. One cycle later `ovr_flag` is set. A new frame that starts while that word is still held overwrites it, and that word never reaches `rd_data`.
- R6: With `ign_fs` = 0, an `fsync` on a `bit_en` cycle during an active frame sets `fse_flag`. Reception restarts with that cycle's bit as the new most significant bit, and the partial word is dropped.
- R7: On such a restart, a word still in the holding buffer that does not move to the data register in that cycle is discarded.
- R8: With `ign_fs` = 1, an `fsync` during an active frame is ignored. The current word completes unchanged, and `fse_flag` is not set.
- R9: `ovr_flag` and `fse_flag` stay set until `clr_ovr` or `clr_fse` is pulsed. A new error in the same cycle as its clear pulse wins.
- R10: After reset, `rd_rdy`, `ovr_flag` and `fse_flag` are 0, `rd_data` is 0, and no frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Serial-clock rising-edge sample strobe |
| fsync | input | 1 | Frame-sync pulse, sampled with bit_en |
| sdata | input | 1 | Serial data bit |
| ign_fs | input | 1 | 1: ignore mid-frame frame syncs |
| rd_stb | input | 1 | Host read of the data register |
| clr_ovr | input | 1 | Write-one-to-clear for ovr_flag |
| clr_fse | input | 1 | Write-one-to-clear for fse_flag |
| rd_data | output | WIDTH | Host data register |
| rd_rdy | output | 1 | Data register holds an unread word |
| ovr_flag | output | 1 | Sticky receive-full (overrun) error |
| fse_flag | output | 1 | Sticky unexpected frame-sync error |

## Verification
The bench fills all three stages and then sends one more frame. A design that let the extra word overwrite the holding buffer, or that left the overrun flag clear, would deliver the wrong third word after two reads. It also aborts a frame with an early sync while a word waits in the holding buffer. A design that failed to discard that word, or that let it slip into the data register, would show it on `rd_data` where the restarted frame's word belongs. With the ignore control set, a mid-frame sync must leave the word intact. A design that restarted would show a shifted word and a raised error flag. Random traffic with reads, clears and control changes mixed in checks the read-then-advance timing against a queue-based model on every cycle.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             fsync,
  input  logic             sdata,
  input  logic             ign_fs,
  input  logic             rd_stb,
  input  logic             clr_ovr,
  input  logic             clr_fse,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_rdy,
  output logic             ovr_flag,
  output logic             fse_flag
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] sr, hold;
  logic [CW-1:0]    cnt;
  logic             sr_v, hold_v;

  logic active, shift_go, restart, abort, done, mv_dr, mv_hold;
  logic [CW-1:0] nxt;

  assign active   = cnt != '0;
  assign shift_go = bit_en && (active || fsync);
  assign restart  = bit_en && fsync && (!active || !ign_fs);
  assign abort    = restart && active;
  assign nxt      = restart ? CW'(1) : cnt + CW'(1);
  assign done     = shift_go && (nxt == CW'(WIDTH));
  assign mv_dr    = hold_v && !rd_rdy;
  assign mv_hold  = sr_v && (!hold_v || mv_dr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sr   <= '0;
      sr_v <= 1'b0;
    end else begin
      if (shift_go) begin
        cnt <= done ? '0 : nxt;
        sr  <= {sr[WIDTH-2:0], sdata};
      end
      if (done)                    sr_v <= 1'b1;
      else if (shift_go || mv_hold) sr_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      hold_v  <= 1'b0;
      rd_data <= '0;
      rd_rdy  <= 1'b0;
    end else begin
      if (mv_hold) begin
        hold   <= sr;
        hold_v <= 1'b1;
      end else if (mv_dr || abort) begin
        hold_v <= 1'b0;
      end
      if (mv_dr) begin
        rd_data <= hold;
        rd_rdy  <= 1'b1;
      end else if (rd_stb) begin
        rd_rdy  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      fse_flag <= 1'b0;
    end else begin
      ovr_flag <= (sr_v && !mv_hold) || (ovr_flag && !clr_ovr);
      fse_flag <= abort || (fse_flag && !clr_fse);
    end
  end
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             fsync,
  input logic             ign_fs,
  input logic             rd_stb,
  input logic             clr_ovr,
  input logic             clr_fse,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_rdy,
  input logic             ovr_flag,
  input logic             fse_flag,
  input logic             busy
);
  // R2
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_rdy |=> !rd_rdy);

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rdy && !rd_stb |=> rd_rdy && $stable(rd_data));

  // R6
  fse_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && fsync && busy && !ign_fs |=> fse_flag);

  // R8
  fse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && fsync && busy && ign_fs && !fse_flag |=> !fse_flag);

  // R9
  fse_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fse_flag && !clr_fse |=> fse_flag);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && !clr_ovr |=> ovr_flag);
endmodule

bind serial_frame_rx serial_frame_rx_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .ign_fs(ign_fs),
  .rd_stb(rd_stb), .clr_ovr(clr_ovr), .clr_fse(clr_fse), .rd_data(rd_data),
  .rd_rdy(rd_rdy), .ovr_flag(ovr_flag), .fse_flag(fse_flag), .busy(cnt != '0)
);

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 0, fsync = 0, sdata = 0, ign_fs = 0, rd_stb = 0, clr_ovr = 0, clr_fse = 0;
  logic [W-1:0] rd_data;
  logic rd_rdy, ovr_flag, fse_flag;

  int vectors = 0, fails = 0, cyc = 0;
  bit run = 0, done_flag = 0;

  always #4 clk = ~clk;

  serial_frame_rx #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .sdata(sdata),
    .ign_fs(ign_fs), .rd_stb(rd_stb), .clr_ovr(clr_ovr), .clr_fse(clr_fse),
    .rd_data(rd_data), .rd_rdy(rd_rdy), .ovr_flag(ovr_flag), .fse_flag(fse_flag)
  );

  int          m_bits;
  logic [W-1:0] m_acc, m_sr, m_dr;
  logic [W-1:0] m_q[$];
  bit          m_srv, m_drv, m_ovr, m_fse;

  always @(posedge clk) begin
    automatic bit b2d, take, ab, first, shifting;
    if (!rst_n) begin
      m_bits = 0; m_acc = '0; m_sr = '0; m_dr = '0; m_q.delete();
      m_srv = 0; m_drv = 0; m_ovr = 0; m_fse = 0;
    end else begin
      b2d      = (m_q.size() != 0) && !m_drv;
      take     = m_srv && (m_q.size() == 0 || b2d);
      ab       = bit_en && fsync && m_bits != 0 && !ign_fs;
      first    = bit_en && fsync && (m_bits == 0 || !ign_fs);
      shifting = bit_en && (m_bits != 0 || fsync);
      m_ovr = (m_srv && !take) || (m_ovr && !clr_ovr);
      m_fse = ab || (m_fse && !clr_fse);
      if (b2d) begin m_dr = m_q.pop_front(); m_drv = 1; end
      else if (rd_stb) m_drv = 0;
      if (ab) m_q.delete();
      if (take) m_q.push_back(m_sr);
      if (shifting) begin
        m_srv = 0;
        if (first) begin m_acc = W'(sdata); m_bits = 1; end
        else begin m_acc = {m_acc[W-2:0], sdata}; m_bits++; end
        if (m_bits == W) begin m_sr = m_acc; m_srv = 1; m_bits = 0; end
      end else if (take) m_srv = 0;
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run) begin
      cmp("R2 rd_rdy", rd_rdy, m_drv);
      if (m_drv) cmp("R1 rd_data", rd_data, m_dr);
      cmp("R5 ovr_flag", ovr_flag, m_ovr);
      cmp("R6 fse_flag", fse_flag, m_fse);
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done_flag) begin
      done_flag = 1;
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected<=100000", cyc);
      report();
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bit_en = 0; fsync = 0; rd_stb = 0; clr_ovr = 0; clr_fse = 0;
    end
  endtask

  task automatic send(input logic [W-1:0] w, input int nb = W, input int fs2 = -1);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      rd_stb = 0; clr_ovr = 0; clr_fse = 0;
      bit_en = 1; fsync = (i == 0) || (i == fs2); sdata = w[W-1-i];
    end
    @(negedge clk);
    bit_en = 0; fsync = 0;
  endtask

  task automatic host_read();
    @(negedge clk);
    bit_en = 0; fsync = 0; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R10 rd_rdy", rd_rdy, 0);
    cmp("R10 ovr_flag", ovr_flag, 0);
    cmp("R10 fse_flag", fse_flag, 0);
    cmp("R10 rd_data", rd_data, 0);
    rst_n = 1;
    run = 1;
    idle(2);

    send(8'hA5); idle(4);
    cmp("R1 first word", rd_data, 8'hA5);
    cmp("R1 ready", rd_rdy, 1);
    send(8'h3C); idle(4);
    cmp("R3 data held", rd_data, 8'hA5);

    send(8'h11, 3); send(8'h96); idle(4);
    cmp("R6 fse set", fse_flag, 1);
    host_read();
    cmp("R2 drop after read", rd_rdy, 0);
    @(negedge clk);
    cmp("R4 advance ready", rd_rdy, 1);
    cmp("R7 buffered word discarded", rd_data, 8'h96);

    @(negedge clk); clr_fse = 1;
    @(negedge clk); clr_fse = 0;
    cmp("R9 fse cleared", fse_flag, 0);

    send(8'h01); send(8'h02); idle(2);
    cmp("R5 ovr set", ovr_flag, 1);
    send(8'h03); idle(3);
    host_read(); idle(2);
    cmp("R3 next word", rd_data, 8'h01);
    host_read(); idle(2);
    cmp("R5 overwritten word lost", rd_data, 8'h03);
    host_read(); idle(2);
    cmp("R2 empty", rd_rdy, 0);

    ign_fs = 1;
    send(8'h5A, W, 4); idle(4);
    cmp("R8 word intact", rd_data, 8'h5A);
    cmp("R8 no fse", fse_flag, 0);
    host_read(); ign_fs = 0;

    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      bit_en  = ($urandom_range(0, 9) < 7);
      fsync   = ($urandom_range(0, 19) == 0);
      sdata   = $urandom_range(0, 1);
      rd_stb  = ($urandom_range(0, 4) == 0);
      clr_ovr = ($urandom_range(0, 29) == 0);
      clr_fse = ($urandom_range(0, 29) == 0);
      if ($urandom_range(0, 199) == 0) ign_fs = ~ign_fs;
    end
    idle(10);
    done_flag = 1;
    report();
  end
endmodule